// File: doc/BRIEF.md
# Dual-Mode Synchronous FIFO

A single-clock first-in first-out buffer for 9-bit words with a power-of-two depth. The operating mode is captured when master reset is applied. In standard mode a read strobe fetches the oldest word into a registered output. In fall-through mode the oldest word is placed on the output without any read strobe, and a read strobe moves the output on to the next word.

Two status outputs change meaning with the mode. In standard mode they are an empty flag and a full flag. In fall-through mode they are output-ready and input-ready. Three more flags work the same way in both modes: half-full, almost-empty and almost-full. The almost thresholds are offsets from the empty and full boundaries. A separate offset unit supplies them as inputs.

A partial reset clears the pointers and the stored occupancy. It keeps the latched mode. Every flag is active-low and is registered. Occupancy counts every word written and not yet read. In fall-through mode this includes the word shown on the output.

Top module: `dmf_fifo`

## Requirements
- R1: `fwft_sel` is sampled on each clock edge where `rst` is high. A value of 1 selects fall-through mode and 0 selects standard mode. The mode holds until the next master reset, and `part_rst` does not change it.
- R2: In standard mode, `out_stat_n` is low exactly when occupancy is 0. `in_stat_n` is low exactly when occupancy equals DEPTH.
- R3: In standard mode, a read with occupancy above 0 loads the oldest word onto `rd_data` at that clock edge. Words leave in the order they were written.
- R4: In fall-through mode, a word written into an empty FIFO at edge k appears on `rd_data` at edge k+1 without any read strobe. `out_stat_n` goes low at edge k+1. A read while `out_stat_n` is low replaces `rd_data` with the next word at that edge. When no word is shown, `out_stat_n` is high.
- R5: In fall-through mode, `in_stat_n` is low exactly when occupancy is below DEPTH.
- R6: `half_n` is low exactly when occupancy is greater than DEPTH/2, in either mode.
- R7: `aempty_n` is low exactly when occupancy is at or below `ae_ofs`, in either mode.
- R8: `afull_n` is low exactly when DEPTH minus occupancy is at or below `af_ofs`, in either mode.
- R9: A write when occupancy equals DEPTH is dropped. A read when there is nothing to read is dropped. Neither moves a pointer or changes occupancy.
- R10: Master reset and partial reset both set occupancy to 0 and the pointers to the first location. All flags then reflect an empty FIFO.
- R11: Every flag is registered. A flag shows the new occupancy at the same clock edge that performs the access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high master reset; latches the mode |
| part_rst | input | 1 | Synchronous active-high partial reset; clears pointers only |
| fwft_sel | input | 1 | Mode select sampled during master reset (1 = fall-through) |
| wr_en | input | 1 | Write strobe |
| wr_data | input | DW | Write data |
| rd_en | input | 1 | Read strobe |
| rd_data | output | DW | Registered read data |
| ae_ofs | input | AW+1 | Almost-empty offset from the empty boundary |
| af_ofs | input | AW+1 | Almost-full offset from the full boundary |
| out_stat_n | output | 1 | Empty flag (standard) or output-ready (fall-through), active low |
| in_stat_n | output | 1 | Full flag (standard) or input-ready (fall-through), active low |
| half_n | output | 1 | Half-full flag, active low |
| aempty_n | output | 1 | Almost-empty flag, active low |
| afull_n | output | 1 | Almost-full flag, active low |

## Verification
A wrong occupancy count shows up on the flags at the same edge as the faulty access. The almost-empty, half-full and almost-full thresholds are crossed one word at a time, so a count that is off by one fails at the first crossing. A pointer that moves when it should not shows up later, as a wrong or repeated word on `rd_data` when the queue drains. The bench therefore drains the FIFO after every overflow and underflow attempt. A mode that changes on partial reset turns both status flags to the other meaning on the very next cycle.

// File: rtl/dmf_pkg.sv
package dmf_pkg;
  typedef enum logic {
    MODE_STD  = 1'b0,
    MODE_FWFT = 1'b1
  } fifo_mode_e;

  typedef struct packed {
    logic out_n;
    logic in_n;
    logic half_n;
    logic ae_n;
    logic af_n;
  } flag_vec_t;
endpackage

// File: rtl/dmf_mem.sv
module dmf_mem #(
  parameter int DW = 9,
  parameter int AW = 4
) (
  input  logic          clk,
  input  logic          clr,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic          re,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] ram [DEPTH];

  always_ff @(posedge clk) begin
    if (we) ram[waddr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (clr)     rdata <= '0;
    else if (re) rdata <= ram[raddr];
  end
endmodule

// File: rtl/dmf_ctrl.sv
module dmf_ctrl
  import dmf_pkg::*;
#(
  parameter int AW = 4,
  localparam int CW = AW + 1
) (
  input  logic          clk,
  input  logic          mrst,
  input  logic          prst,
  input  logic          mode_sel,
  input  logic          wr_en,
  input  logic          rd_en,
  output logic          we,
  output logic          re,
  output logic [AW-1:0] waddr,
  output logic [AW-1:0] raddr,
  output fifo_mode_e    mode_q,
  output fifo_mode_e    mode_eff,
  output logic [CW-1:0] occ_q,
  output logic [CW-1:0] occ_nxt,
  output logic          shown_nxt
);
  localparam logic [CW-1:0] FULLV = CW'(1 << AW);

  logic [AW-1:0] wptr, rptr;
  logic [CW-1:0] mcnt, mcnt_n;
  logic          shown, shown_n, pop, clr;

  assign clr   = mrst | prst;
  assign waddr = wptr;
  assign raddr = rptr;
  assign occ_q = mcnt + CW'(shown);

  always_comb begin
    we = wr_en && (occ_q != FULLV);
    if (mode_q == MODE_FWFT) begin
      pop     = rd_en && shown;
      re      = (mcnt != '0) && (!shown || pop);
      shown_n = re | (shown & ~pop);
    end else begin
      pop     = rd_en && (mcnt != '0);
      re      = pop;
      shown_n = 1'b0;
    end
    mcnt_n    = mcnt + CW'(we) - CW'(re);
    occ_nxt   = clr ? '0 : mcnt_n + CW'(shown_n);
    shown_nxt = clr ? 1'b0 : shown_n;
    mode_eff  = mrst ? fifo_mode_e'(mode_sel) : mode_q;
  end

  always_ff @(posedge clk) begin
    if (mrst) mode_q <= fifo_mode_e'(mode_sel);
  end

  always_ff @(posedge clk) begin
    if (clr) begin
      wptr  <= '0;
      rptr  <= '0;
      mcnt  <= '0;
      shown <= 1'b0;
    end else begin
      wptr  <= wptr + AW'(we);
      rptr  <= rptr + AW'(re);
      mcnt  <= mcnt_n;
      shown <= shown_n;
    end
  end
endmodule

// File: rtl/dmf_flags.sv
module dmf_flags
  import dmf_pkg::*;
#(
  parameter int AW = 4,
  localparam int CW = AW + 1
) (
  input  logic          clk,
  input  fifo_mode_e    mode,
  input  logic [CW-1:0] occ_nxt,
  input  logic          shown_nxt,
  input  logic [CW-1:0] ae_ofs,
  input  logic [CW-1:0] af_ofs,
  output flag_vec_t     flags_q
);
  localparam logic [CW-1:0] FULLV = CW'(1 << AW);
  localparam logic [CW-1:0] HALFV = CW'(1 << (AW - 1));

  flag_vec_t f;

  always_comb begin
    if (mode == MODE_FWFT) begin
      f.out_n = ~shown_nxt;
      f.in_n  = (occ_nxt == FULLV);
    end else begin
      f.out_n = (occ_nxt != '0);
      f.in_n  = (occ_nxt != FULLV);
    end
    f.half_n = !(occ_nxt > HALFV);
    f.ae_n   = !(occ_nxt <= ae_ofs);
    f.af_n   = !((FULLV - occ_nxt) <= af_ofs);
  end

  always_ff @(posedge clk) flags_q <= f;
endmodule

// File: rtl/dmf_fifo.sv
module dmf_fifo
  import dmf_pkg::*;
#(
  parameter int DW = 9,
  parameter int AW = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          part_rst,
  input  logic          fwft_sel,
  input  logic          wr_en,
  input  logic [DW-1:0] wr_data,
  input  logic          rd_en,
  output logic [DW-1:0] rd_data,
  input  logic [AW:0]   ae_ofs,
  input  logic [AW:0]   af_ofs,
  output logic          out_stat_n,
  output logic          in_stat_n,
  output logic          half_n,
  output logic          aempty_n,
  output logic          afull_n
);
  localparam int CW = AW + 1;

  logic          we, re, shown_nxt;
  logic [AW-1:0] waddr, raddr;
  logic [CW-1:0] occ_q, occ_nxt;
  fifo_mode_e    mode_q, mode_eff;
  flag_vec_t     flags;

  dmf_ctrl #(.AW(AW)) u_ctrl (
    .clk(clk), .mrst(rst), .prst(part_rst), .mode_sel(fwft_sel),
    .wr_en(wr_en), .rd_en(rd_en), .we(we), .re(re),
    .waddr(waddr), .raddr(raddr), .mode_q(mode_q), .mode_eff(mode_eff),
    .occ_q(occ_q), .occ_nxt(occ_nxt), .shown_nxt(shown_nxt)
  );

  dmf_mem #(.DW(DW), .AW(AW)) u_mem (
    .clk(clk), .clr(rst | part_rst), .we(we), .waddr(waddr), .wdata(wr_data),
    .re(re), .raddr(raddr), .rdata(rd_data)
  );

  dmf_flags #(.AW(AW)) u_flags (
    .clk(clk), .mode(mode_eff), .occ_nxt(occ_nxt), .shown_nxt(shown_nxt),
    .ae_ofs(ae_ofs), .af_ofs(af_ofs), .flags_q(flags)
  );

  assign out_stat_n = flags.out_n;
  assign in_stat_n  = flags.in_n;
  assign half_n     = flags.half_n;
  assign aempty_n   = flags.ae_n;
  assign afull_n    = flags.af_n;
endmodule

// File: rtl/dmf_fifo_chk.sv
module dmf_fifo_chk
  import dmf_pkg::*;
#(
  parameter int AW = 4,
  localparam int CW = AW + 1
) (
  input logic          clk,
  input logic          rst,
  input logic          prst,
  input logic          wr_en,
  input logic          rd_en,
  input fifo_mode_e    mode,
  input logic [CW-1:0] occ,
  input logic          out_n,
  input logic          in_n,
  input logic          half_n
);
  localparam logic [CW-1:0] FULLV = CW'(1 << AW);
  localparam logic [CW-1:0] HALFV = CW'(1 << (AW - 1));

  // R9
  no_overflow_chk: assert property (@(posedge clk) disable iff (rst || prst)
    (occ == FULLV && wr_en && !rd_en) |=> (occ == FULLV));

  // R9
  no_underflow_chk: assert property (@(posedge clk) disable iff (rst || prst)
    (occ == '0 && rd_en && !wr_en) |=> (occ == '0));

  // R2
  std_flag_chk: assert property (@(posedge clk) disable iff (rst || prst)
    (mode == MODE_STD) |-> (out_n == (occ != '0)) && (in_n == (occ != FULLV)));

  // R5
  fwft_ir_chk: assert property (@(posedge clk) disable iff (rst || prst)
    (mode == MODE_FWFT) |-> (in_n == (occ == FULLV)));

  // R4
  fwft_first_word_chk: assert property (@(posedge clk) disable iff (rst || prst)
    (mode == MODE_FWFT && occ == '0 && wr_en) |=> out_n ##1 !out_n);

  // R6
  half_flag_chk: assert property (@(posedge clk) disable iff (rst || prst)
    1'b1 |-> (half_n == !(occ > HALFV)));

  // R1
  mode_hold_chk: assert property (@(posedge clk) disable iff (rst)
    prst |=> $stable(mode));

  // R10
  occ_range_chk: assert property (@(posedge clk) disable iff (rst)
    1'b1 |-> (occ <= FULLV));
endmodule

bind dmf_fifo dmf_fifo_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst(rst), .prst(part_rst), .wr_en(wr_en), .rd_en(rd_en),
  .mode(mode_q), .occ(occ_q), .out_n(out_stat_n), .in_n(in_stat_n),
  .half_n(half_n)
);

// File: tb/dmf_fifo_bench.sv
module dmf_fifo_bench;
  localparam int DW = 9;
  localparam int AW = 4;
  localparam int DEPTH = 1 << AW;
  localparam int AE = 2;
  localparam int AF = 3;

  logic          clk = 1'b0;
  logic          rst = 1'b1, part_rst = 1'b0, fwft_sel = 1'b0;
  logic          wr_en = 1'b0, rd_en = 1'b0;
  logic [DW-1:0] wr_data = '0;
  logic [DW-1:0] rd_data;
  logic [AW:0]   ae_ofs = (AW+1)'(AE);
  logic [AW:0]   af_ofs = (AW+1)'(AF);
  logic          out_stat_n, in_stat_n, half_n, aempty_n, afull_n;

  int checks = 0, fails = 0;
  int mocc = 0;
  bit mfwft = 1'b0;
  bit done = 1'b0;
  int q[$];

  always #5 clk = ~clk;

  dmf_fifo #(.DW(DW), .AW(AW)) u_dmf_fifo (
    .clk(clk), .rst(rst), .part_rst(part_rst), .fwft_sel(fwft_sel),
    .wr_en(wr_en), .wr_data(wr_data), .rd_en(rd_en), .rd_data(rd_data),
    .ae_ofs(ae_ofs), .af_ofs(af_ofs), .out_stat_n(out_stat_n),
    .in_stat_n(in_stat_n), .half_n(half_n), .aempty_n(aempty_n), .afull_n(afull_n)
  );

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h (t=%0t)", req, act, exp, $time);
    end
  endtask

  task automatic check_flags(string tag);
    check({tag, " R6 half"}, half_n, !(mocc > DEPTH/2));
    check({tag, " R7 aempty"}, aempty_n, !(mocc <= AE));
    check({tag, " R8 afull"}, afull_n, !((DEPTH - mocc) <= AF));
    if (mfwft) check({tag, " R5 in_stat"}, in_stat_n, (mocc == DEPTH));
    else begin
      check({tag, " R2 in_stat"}, in_stat_n, (mocc != DEPTH));
      check({tag, " R2 out_stat"}, out_stat_n, (mocc != 0));
    end
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic do_mrst(bit fw);
    @(negedge clk);
    rst = 1'b1; fwft_sel = fw;
    idle(2);
    rst = 1'b0; fwft_sel = ~fw;
    mfwft = fw; mocc = 0; q.delete();
  endtask

  task automatic do_prst();
    @(negedge clk);
    part_rst = 1'b1;
    @(negedge clk);
    part_rst = 1'b0;
    mocc = 0; q.delete();
  endtask

  task automatic push(int v);
    @(negedge clk);
    wr_en = 1'b1; wr_data = DW'(v);
    @(negedge clk);
    wr_en = 1'b0;
    if (mocc < DEPTH) begin q.push_back(v & ((1 << DW) - 1)); mocc++; end
  endtask

  task automatic pop_std(string tag);
    int exp;
    @(negedge clk);
    rd_en = 1'b1;
    @(negedge clk);
    rd_en = 1'b0;
    if (mocc > 0) begin
      exp = q.pop_front(); mocc--;
      check({tag, " R3 data"}, rd_data, exp);
    end
  endtask

  task automatic pop_fwft(string tag);
    check({tag, " R4 ready"}, out_stat_n, 0);
    check({tag, " R4 head"}, rd_data, q[0]);
    @(negedge clk);
    rd_en = 1'b1;
    @(negedge clk);
    rd_en = 1'b0;
    void'(q.pop_front()); mocc--;
  endtask

  task automatic t_reset_std();
    do_mrst(1'b0);
    check("R10 reset out_stat", out_stat_n, 0);
    check("R10 reset in_stat", in_stat_n, 1);
    check("R10 reset half", half_n, 1);
    check("R10 reset aempty", aempty_n, 0);
    check("R10 reset afull", afull_n, 1);
  endtask

  task automatic t_std_fill_drain();
    for (int i = 0; i < DEPTH; i++) begin
      push(i * 37 + 5);
      check_flags("R11 std fill");
    end
    push(9'h1AA);
    check("R9 overflow in_stat", in_stat_n, 0);
    check_flags("R9 std full");
    while (mocc > 0) begin
      pop_std("std drain");
      check_flags("R11 std drain");
    end
    @(negedge clk); rd_en = 1'b1;
    @(negedge clk); rd_en = 1'b0;
    check("R9 underflow out_stat", out_stat_n, 0);
    push(9'h055);
    check("R9 after underflow out_stat", out_stat_n, 1);
    pop_std("R9 ptr kept");
  endtask

  task automatic t_prst_std();
    for (int i = 0; i < 5; i++) push(9'h0C0 + i);
    do_prst();
    check("R10 prst out_stat", out_stat_n, 0);
    check("R1 prst keeps std in_stat", in_stat_n, 1);
    check_flags("R10 prst std");
    push(9'h0F0);
    pop_std("R10 prst std reuse");
  endtask

  task automatic t_fwft();
    do_mrst(1'b1);
    check("R1 fwft out_stat", out_stat_n, 1);
    check("R1 fwft in_stat", in_stat_n, 0);
    push(9'h123);
    check("R4 not yet shown", out_stat_n, 1);
    check_flags("R11 fwft first");
    idle(1);
    check("R4 fell through flag", out_stat_n, 0);
    check("R4 fell through data", rd_data, 9'h123);
    for (int i = 1; i < DEPTH; i++) begin
      push(i * 29 + 3);
      check_flags("R5 fwft fill");
    end
    push(9'h0EE);
    check_flags("R9 fwft full");
    while (mocc > 0) begin
      pop_fwft("fwft drain");
      check_flags("R11 fwft drain");
    end
    check("R4 drained not ready", out_stat_n, 1);
  endtask

  task automatic t_prst_fwft();
    for (int i = 0; i < 3; i++) push(9'h010 + i);
    idle(1);
    do_prst();
    check("R1 prst keeps fwft out_stat", out_stat_n, 1);
    check("R1 prst keeps fwft in_stat", in_stat_n, 0);
    check_flags("R10 prst fwft");
    push(9'h0AB);
    idle(1);
    check("R10 prst fwft data", rd_data, 9'h0AB);
    do_mrst(1'b0);
    check("R1 mrst back to std out_stat", out_stat_n, 0);
    check("R1 mrst back to std in_stat", in_stat_n, 1);
  endtask

  initial begin
    t_reset_std();
    t_std_fill_drain();
    t_prst_std();
    t_fwft();
    t_prst_fwft();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    #(200000 * 10);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end
endmodule